// File: doc/BRIEF.md
# Three-Wire Display Frame Receiver

This block takes display frames from a host over a three-wire link: a data line, a shift clock and a load strobe. All three lines are asynchronous to the block clock. They pass through a two-flop synchronizer. Each rising edge of the shift clock moves one data bit into a 48-bit history register, so the register always holds the 48 most recent bits. A frame is 40 segment bits followed by an 8-bit command field. The segment for output 40 is sent first, and command bit C7 is sent last.

When the load strobe rises, the block decodes the command from the history register as it stood just before that edge. There are four commands:
- Store three frame-rate bits.
- Set or clear the display-enable flag.
- Do nothing.
- Write the segment bits into one of four common-row latches, but only when the four address bits in the frame match the strap inputs.

During a write, the selected row is transparent for as long as load stays high. It keeps its last value once load falls.

Top module: `lcd_ser_rx`

## Requirements
- R1: On each rising edge of `ser_clk_i`, the level of `ser_data_i` is shifted in. The history register then holds the latest 48 bits, and any extra leading padding bits drop out.
- R2: Segment bits map by arrival order. The first of the 48 bits lands at segment 40 (row bit 39). The 40th bit lands at segment 1 (row bit 0).
- R3: The command byte is the last 8 bits received. C0 arrives first and C7 arrives last. The opcode is {C7,C6}.
- R4: Opcode 00 changes no output.
- R5: Opcode 01 loads `frame_freq_o` with {C5,C4,C3}.
- R6: Opcode 10 with C5=1 loads `disp_on_o` with C4. Opcode 10 with C5=0 changes nothing.
- R7: Opcode 11 with {C5,C4,C3,C2} equal to `strap_i[3:0]` targets row {C1,C0}, where row r occupies `seg_rows_o[r*40 +: 40]`. While load stays high, that row follows the 40 segment bits. After load falls it holds.
- R8: Opcode 11 with an address mismatch leaves all four rows unchanged.
- R9: A settings command works from a short frame of only C4..C7. Any bits the frame omits are taken from the older history.
- R10: While `rst_ni` is low, all rows, `frame_freq_o` and `disp_on_o` are 0.
- R11: The command is decoded from the content before the load rise. This holds even when a shift-clock rise is seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_load_i | input | 1 | Load strobe |
| strap_i | input | 4 | Chip address straps {SA1,SA0,A1,A0} |
| seg_rows_o | output | 160 | Four row latches, row r at bits r*40+39..r*40 |
| frame_freq_o | output | 3 | Frame-rate setting {F1,F0,FSEL} |
| disp_on_o | output | 1 | Display enable |

## Verification
A shift-clock rise and a load rise can land in the same synchronized cycle. In that cycle the history register shifts while the command is decoded. The bench provokes this by raising both lines together, once after a write frame and once after a frame-rate frame. The decoded command must come from the pre-shift content. The written row must then show the post-shift segment window, because the row stays transparent while load is high.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;
  localparam int SEG_W  = 40;
  localparam int CMD_W  = 8;
  localparam int ROWS   = 4;
  localparam int ADDR_W = 4;
  localparam int FRM_W  = SEG_W + CMD_W;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_FREQ  = 2'b01,
    OP_DISP  = 2'b10,
    OP_WRITE = 2'b11
  } op_e;
endpackage

// File: rtl/lcd_ser_sync.sv
module lcd_ser_sync #(
  parameter int N_BITS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] in_i,
  output logic [N_BITS-1:0] out_o
);
  logic [N_BITS-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= in_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign out_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcd_ser_shift.sv
module lcd_ser_shift #(
  parameter int FRM_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [FRM_W-1:0] sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         sr_o <= '0;
    else if (shift_en_i) sr_o <= {sr_o[FRM_W-2:0], bit_i};
endmodule

// File: rtl/lcd_ser_decode.sv
module lcd_ser_decode
  import lcd_ser_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 4,
  parameter int ROWS   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_rise_i,
  input  logic                    load_fall_i,
  input  logic [CMD_W-1:0]        cmd_i,
  input  logic [ADDR_W-1:0]       strap_i,
  output logic [2:0]              freq_o,
  output logic                    disp_on_o,
  output logic                    wr_active_o,
  output logic [$clog2(ROWS)-1:0] row_sel_o
);
  localparam int ROW_W = $clog2(ROWS);

  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic              addr_hit;

  assign op       = op_e'(cmd_i[CMD_W-1 -: 2]);
  assign addr     = cmd_i[ROW_W +: ADDR_W];
  assign addr_hit = (addr == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o      <= '0;
      disp_on_o   <= 1'b0;
      wr_active_o <= 1'b0;
      row_sel_o   <= '0;
    end else if (load_rise_i) begin
      unique case (op)
        OP_FREQ:  freq_o <= cmd_i[CMD_W-3 -: 3];
        OP_DISP:  if (cmd_i[CMD_W-3]) disp_on_o <= cmd_i[CMD_W-4];
        OP_WRITE: begin
          wr_active_o <= addr_hit;
          row_sel_o   <= cmd_i[ROW_W-1:0];
        end
        default: ;
      endcase
    end else if (load_fall_i) begin
      wr_active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_ser_rows.sv
module lcd_ser_rows #(
  parameter int SEG_W = 40,
  parameter int ROWS  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_active_i,
  input  logic [$clog2(ROWS)-1:0]       row_sel_i,
  input  logic [SEG_W-1:0]              seg_i,
  output logic [ROWS-1:0][SEG_W-1:0]    rows_o
);
  localparam int ROW_W = $clog2(ROWS);

  logic [SEG_W-1:0] row_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                    row_q[r] <= '0;
      else if (wr_active_i && row_sel_i == ROW_W'(r)) row_q[r] <= seg_i;
    assign rows_o[r] = row_q[r];
  end
endmodule

// File: rtl/lcd_ser_rx.sv
module lcd_ser_rx
  import lcd_ser_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ser_data_i,
  input  logic                  ser_clk_i,
  input  logic                  ser_load_i,
  input  logic [ADDR_W-1:0]     strap_i,
  output logic [ROWS*SEG_W-1:0] seg_rows_o,
  output logic [2:0]            frame_freq_o,
  output logic                  disp_on_o
);
  localparam int ROW_W = $clog2(ROWS);

  logic [2:0]             sync_out;
  logic                   data_s, clk_s, load_s;
  logic                   clk_prev_q, load_prev_q;
  logic                   ser_clk_rise, load_rise, load_fall;
  logic [FRM_W-1:0]       sr;
  logic [CMD_W-1:0]       cmd;
  logic                   wr_active;
  logic [ROW_W-1:0]       row_sel;
  logic [ROWS-1:0][SEG_W-1:0] rows;

  lcd_ser_sync #(.N_BITS(3), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({ser_load_i, ser_clk_i, ser_data_i}),
    .out_o (sync_out)
  );
  assign {load_s, clk_s, data_s} = sync_out;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      clk_prev_q  <= 1'b0;
      load_prev_q <= 1'b0;
    end else begin
      clk_prev_q  <= clk_s;
      load_prev_q <= load_s;
    end

  assign ser_clk_rise = clk_s & ~clk_prev_q;
  assign load_rise    = load_s & ~load_prev_q;
  assign load_fall    = ~load_s & load_prev_q;

  lcd_ser_shift #(.FRM_W(FRM_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(ser_clk_rise),
    .bit_i     (data_s),
    .sr_o      (sr)
  );

  // last bit in is C7: reverse the trailing byte into C7..C0
  always_comb
    for (int n = 0; n < CMD_W; n++) cmd[n] = sr[CMD_W-1-n];

  lcd_ser_decode #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .ROWS(ROWS)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_rise_i(load_rise),
    .load_fall_i(load_fall),
    .cmd_i      (cmd),
    .strap_i    (strap_i),
    .freq_o     (frame_freq_o),
    .disp_on_o  (disp_on_o),
    .wr_active_o(wr_active),
    .row_sel_o  (row_sel)
  );

  // first bit in (segment 40) sits at the top of the history
  lcd_ser_rows #(.SEG_W(SEG_W), .ROWS(ROWS)) u_rows (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_active_i(wr_active),
    .row_sel_i  (row_sel),
    .seg_i      (sr[FRM_W-1:CMD_W]),
    .rows_o     (rows)
  );

  assign seg_rows_o = rows;
endmodule

// File: rtl/lcd_ser_rx_chk.sv
module lcd_ser_rx_chk
  import lcd_ser_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clk_rise_i,
  input logic                       load_rise_i,
  input logic [FRM_W-1:0]           sr_i,
  input logic                       wr_active_i,
  input logic [$clog2(ROWS)-1:0]    row_sel_i,
  input logic [ROWS-1:0][SEG_W-1:0] rows_i,
  input logic [2:0]                 frame_freq_i,
  input logic                       disp_on_i
);
  logic [$clog2(ROWS)-1:0] row_sel_d;
  logic [SEG_W-1:0]        seg_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      row_sel_d <= '0;
      seg_d     <= '0;
    end else begin
      row_sel_d <= row_sel_i;
      seg_d     <= sr_i[FRM_W-1:CMD_W];
    end

  a_r1_shift_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_rise_i |=> sr_i[FRM_W-1:1] == $past(sr_i[FRM_W-2:0]));

  a_r5_freq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_rise_i |=> $stable(frame_freq_i));

  a_r6_disp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_rise_i |=> $stable(disp_on_i));

  a_r8_rows_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_active_i |=> $stable(rows_i));

  a_r7_row_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_active_i |=> rows_i[row_sel_d] == seg_d);

  a_r11_pre_edge_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_rise_i && !sr_i[0] && sr_i[1]) |=>
      frame_freq_i == $past({sr_i[2], sr_i[3], sr_i[4]}));
endmodule

bind lcd_ser_rx lcd_ser_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clk_rise_i  (ser_clk_rise),
  .load_rise_i (load_rise),
  .sr_i        (sr),
  .wr_active_i (wr_active),
  .row_sel_i   (row_sel),
  .rows_i      (rows),
  .frame_freq_i(frame_freq_o),
  .disp_on_i   (disp_on_o)
);

// File: tb/lcd_ser_rx_bench.sv
`timescale 1ns/1ps
module lcd_ser_rx_bench;
  localparam int HALF = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
  logic [3:0]   strap = 4'b1010;
  logic [159:0] seg_rows;
  logic [2:0]   frame_freq;
  logic         disp_on;

  always #4 clk = ~clk;

  lcd_ser_rx u_lcd_ser_rx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ser_data_i  (ser_data),
    .ser_clk_i   (ser_clk),
    .ser_load_i  (ser_load),
    .strap_i     (strap),
    .seg_rows_o  (seg_rows),
    .frame_freq_o(frame_freq),
    .disp_on_o   (disp_on)
  );

  typedef struct {
    logic [159:0] rows;
    logic [2:0]   freq;
    logic         disp;
    string        tag;
  } exp_t;

  exp_t              sb_q[$];
  int                checks = 0, failures = 0;
  logic [47:0]       hist = '0;
  logic [3:0][39:0]  e_rows = '0;
  logic [2:0]        e_freq = '0;
  logic              e_disp = 1'b0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    cyc(HALF);
    ser_clk = 1'b1;
    cyc(HALF);
    ser_clk = 1'b0;
    hist = {hist[46:0], b};
  endtask

  // seg[i] is segment i+1; segment 40 goes out first, C7 last (R2, R3)
  task automatic send_frame(input logic [39:0] seg, input logic [7:0] cmd);
    for (int i = 39; i >= 0; i--) send_bit(seg[i]);
    for (int n = 0; n < 8; n++) send_bit(cmd[n]);
  endtask

  // strobe load; with_clk raises the shift clock in the same instant (R11)
  task automatic load_cycle(input string tag, input logic with_clk, input logic b);
    logic [7:0] c;
    logic       wr;
    logic [1:0] row;
    exp_t       it;
    for (int n = 0; n < 8; n++) c[n] = hist[7-n];
    wr = 1'b0;
    row = c[1:0];
    case (c[7:6])
      2'b01: e_freq = c[5:3];
      2'b10: if (c[5]) e_disp = c[4];
      2'b11: wr = (c[5:2] == strap);
      default: ;
    endcase
    if (with_clk) begin
      ser_data = b;
      cyc(HALF);
      ser_clk  = 1'b1;
      ser_load = 1'b1;
      hist = {hist[46:0], b};
      cyc(2*HALF);
      ser_clk = 1'b0;
    end else begin
      ser_load = 1'b1;
      cyc(2*HALF);
    end
    cyc(HALF);
    ser_load = 1'b0;
    cyc(2*HALF);
    if (wr) e_rows[row] = hist[47:8];
    it.rows = e_rows;
    it.freq = e_freq;
    it.disp = e_disp;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      wait (sb_q.size() > 0);
      cyc(3);
      it = sb_q.pop_front();
      check(it.tag, "rows", seg_rows, it.rows);
      check(it.tag, "freq", {157'd0, frame_freq}, {157'd0, it.freq});
      check(it.tag, "disp", {159'd0, disp_on}, {159'd0, it.disp});
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin : stim
    cyc(3);
    // R10: reset state
    check("R10", "rows", seg_rows, '0);
    check("R10", "freq", {157'd0, frame_freq}, '0);
    check("R10", "disp", {159'd0, disp_on}, '0);
    rst_n = 1'b1;
    cyc(4);

    // R2/R7: write row 0, address 1010 matches straps
    send_frame(40'h80_1234_5601, {2'b11, 4'b1010, 2'b00});
    load_cycle("R2", 1'b0, 1'b0);
    // R7: write row 3
    send_frame(40'hA5_0F0F_F0C3, {2'b11, 4'b1010, 2'b11});
    load_cycle("R7", 1'b0, 1'b0);
    // R8: address mismatch, row 1 untouched
    send_frame(40'hFF_FFFF_FFFF, {2'b11, 4'b0110, 2'b01});
    load_cycle("R8", 1'b0, 1'b0);
    // R4: opcode 00 ignored
    send_frame(40'h12_3456_789A, {2'b00, 6'b111111});
    load_cycle("R4", 1'b0, 1'b0);
    // R5: frame rate 101
    send_frame(40'h00_0000_0000, {2'b01, 3'b101, 3'b000});
    load_cycle("R5", 1'b0, 1'b0);
    // R6: display on
    send_frame(40'h00_0000_0000, {2'b10, 2'b11, 4'b0000});
    load_cycle("R6", 1'b0, 1'b0);
    // R6: C5=0 ignored, display stays on
    send_frame(40'h00_0000_0000, {2'b10, 2'b00, 4'b0000});
    load_cycle("R6", 1'b0, 1'b0);
    // R9: short frame C4..C7 = 0,1,0,1 -> display off
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    load_cycle("R9", 1'b0, 1'b0);
    // R9: short frame C4..C7 = 1,1,1,0 -> frame rate {1,1,stale C3}
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    load_cycle("R9", 1'b0, 1'b0);
    // R1: three padding bits lead a row-1 write
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_frame(40'h3C_00FF_AA55, {2'b11, 4'b1010, 2'b01});
    load_cycle("R1", 1'b0, 1'b0);
    // R11: shift edge together with load rise after a row-2 write
    send_frame(40'hC0_FFEE_0011, {2'b11, 4'b1010, 2'b10});
    load_cycle("R11", 1'b1, 1'b1);
    // R11: same collision after a frame-rate command
    send_frame(40'h00_0000_0000, {2'b01, 3'b011, 3'b000});
    load_cycle("R11", 1'b1, 1'b0);
    // R3: opcode set by the last byte only
    send_frame(40'hFF_0000_00FF, {2'b01, 3'b010, 3'b111});
    load_cycle("R3", 1'b0, 1'b0);

    wait (sb_q.size() == 0);
    cyc(10);
    finish_run();
  end
endmodule